// File: doc/BRIEF.md
# Target Read-Data Alignment Feeder

This block sits between the user application and the target read FIFO of a bus target controller. During the read data phase, the application offers one 32-bit word on each cycle in which its read-data enable is high. The feeder decides which of those words go into the FIFO. It also drives an active-low marker that tells the application which word is the final one of the phase.

A phase is armed by a one-cycle `start` pulse. The pulse carries four things: the number of 32-bit words the bus side asked for, a burst flag, a 64-bit-agent flag and bit 2 of the bus start address.

- **Aligned transfers** are bursts, or any transfer made by a 64-bit agent. The feeder treats the phase as starting and ending on 64-bit boundaries, so the application always supplies an even number of words. When address bit 2 is set, the first supplied word is swallowed and never written.
- **Plain single transfers** on a 32-bit bus are passed straight through with no padding.

A word counter tracks the words still owed. It pulls the last marker low while the final word is being offered.

Top module: `rd_align_feeder`

## Requirements
- R1: After reset, `fifo_wr` is 0, `last_n` is 1 and the block is idle (no phase armed).
- R2: `start` arms a phase only while idle and only if the computed total is nonzero. A `start` pulse during an armed phase has no effect on the word count or on which words are written.
- R3: Aligned transfer (`burst`=1 or `agent64`=1) with `addr_b2`=0: the phase accepts `xfer_count` rounded up to the next even number of words, and writes every one of them in order.
- R4: Aligned transfer with `addr_b2`=1: the phase accepts `xfer_count`+1 rounded up to the next even number of words. The first accepted word is not written; every later one is written.
- R5: Non-aligned transfer (`burst`=0 and `agent64`=0): exactly `xfer_count` words are accepted and all are written, whatever `addr_b2` is.
- R6: `last_n` is 0 exactly when a phase is armed, `rd_en` is 1 and one word remains; otherwise it is 1. For a one-word non-aligned read it therefore stays low for every cycle `rd_en` is high.
- R7: A cycle with `rd_en`=1 and `fifo_full`=1 writes nothing and leaves the remaining count unchanged.
- R8: A word is accepted on a clock edge where a phase is armed, `rd_en`=1 and `fifo_full`=0. A written word appears as a one-cycle `fifo_wr` pulse in the following cycle, with `fifo_data` equal to the accepted `rd_data`.
- R9: `rd_en` while idle writes nothing.
- R10: A non-aligned `start` with `xfer_count`=0 leaves the block idle, so later `rd_en` cycles write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse arming a read data phase |
| xfer_count | input | CNT_W | Number of 32-bit words requested by the bus side |
| burst | input | 1 | Transfer is a burst |
| agent64 | input | 1 | Target acts as a 64-bit agent |
| addr_b2 | input | 1 | Bit 2 of the bus start address |
| rd_en | input | 1 | Application offers a read data word this cycle |
| rd_data | input | DATA_W | Read data word from the application |
| fifo_full | input | 1 | Target read FIFO is full |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | DATA_W | Word written to the FIFO |
| last_n | output | 1 | Active-low marker for the final word of the phase |

## Verification
The assertions assume that `fifo_full` and `rd_en` are stable between clock edges. They also assume `start` is a single-cycle pulse, which a correct application holds to.

The bench checks outputs against a model built from the rules above. It deliberately breaks the rule about offering words while the FIFO is full, so that R7 is exercised rather than assumed. The stimulus drives inputs only at the falling edge. It keeps `xfer_count` small, so every phase closes well inside the run length.

// File: rtl/rdf_pkg.sv
package rdf_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/rdf_plan.sv
module rdf_plan #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] count,
    input  logic             burst,
    input  logic             agent64,
    input  logic             addr_b2,
    output logic [CNT_W:0]   total,
    output logic             drop_first
);
    localparam int TW = CNT_W + 1;

    logic          align;
    logic [TW-1:0] ext;

    always_comb begin
        align = burst | agent64;
        ext   = {1'b0, count} + TW'(align & addr_b2);
        if (align) begin
            // round up to an even number of 32-bit words
            total = ext + TW'(ext[0]);
        end else begin
            total = ext;
        end
        drop_first = align & addr_b2;
    end
endmodule

// File: rtl/rdf_seq.sv
module rdf_seq
    import rdf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [CNT_W:0] total,
    input  logic           drop_first,
    input  logic           rd_en,
    input  logic           fifo_full,
    output logic           accept,
    output logic           skip,
    output logic           final_word
);
    localparam int TW = CNT_W + 1;

    typedef struct packed {
        phase_e        ph;
        logic          drop;
        logic          first;
        logic [TW-1:0] rem;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        accept     = (st_q.ph == PH_RUN) && rd_en && !fifo_full;
        skip       = st_q.first && st_q.drop;
        final_word = (st_q.ph == PH_RUN) && (st_q.rem == TW'(1));

        if (st_q.ph == PH_IDLE) begin
            if (start && (total != '0)) begin
                st_d.ph    = PH_RUN;
                st_d.rem   = total;
                st_d.drop  = drop_first;
                st_d.first = 1'b1;
            end
        end else if (accept) begin
            st_d.rem   = st_q.rem - TW'(1);
            st_d.first = 1'b0;
            if (st_q.rem == TW'(1)) begin
                st_d.ph = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, drop: 1'b0, first: 1'b0, rem: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rdf_wr.sv
module rdf_wr #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              skip,
    input  logic [DATA_W-1:0] rd_data,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data
);
    typedef struct packed {
        logic              wr;
        logic [DATA_W-1:0] data;
    } wr_t;

    wr_t w_d, w_q;

    always_comb begin
        w_d    = w_q;
        w_d.wr = accept && !skip;
        if (accept && !skip) begin
            w_d.data = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign fifo_wr   = w_q.wr;
    assign fifo_data = w_q.data;
endmodule

// File: rtl/rd_align_feeder.sv
module rd_align_feeder #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  xfer_count,
    input  logic              burst,
    input  logic              agent64,
    input  logic              addr_b2,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_data,
    output logic              last_n
);
    logic [CNT_W:0] total;
    logic           drop_first;
    logic           accept;
    logic           skip;
    logic           final_word;

    rdf_plan #(.CNT_W(CNT_W)) u_plan (
        .count      (xfer_count),
        .burst      (burst),
        .agent64    (agent64),
        .addr_b2    (addr_b2),
        .total      (total),
        .drop_first (drop_first)
    );

    rdf_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .total      (total),
        .drop_first (drop_first),
        .rd_en      (rd_en),
        .fifo_full  (fifo_full),
        .accept     (accept),
        .skip       (skip),
        .final_word (final_word)
    );

    rdf_wr #(.DATA_W(DATA_W)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .skip      (skip),
        .rd_data   (rd_data),
        .fifo_wr   (fifo_wr),
        .fifo_data (fifo_data)
    );

    // marker is only meaningful while the application offers a word
    assign last_n = !(final_word && rd_en);
endmodule

// File: rtl/rd_align_feeder_chk.sv
module rd_align_feeder_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              fifo_full,
    input logic              fifo_wr,
    input logic [DATA_W-1:0] fifo_data,
    input logic              last_n
);
    // R8
    wr_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> $past(rd_en && !fifo_full));

    // R8
    wr_data_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> (fifo_data == $past(rd_data)));

    // R7
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fifo_full) |=> !fifo_wr);

    // R9
    no_write_without_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !fifo_wr);

    // R6
    last_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last_n |-> rd_en);

    // R6
    last_closes_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!last_n && !fifo_full) |=> last_n);
endmodule

bind rd_align_feeder rd_align_feeder_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .fifo_full (fifo_full),
    .fifo_wr   (fifo_wr),
    .fifo_data (fifo_data),
    .last_n    (last_n)
);

// File: tb/sim_rd_align_feeder.sv
module sim_rd_align_feeder;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  xfer_count = '0;
    logic              burst = 1'b0;
    logic              agent64 = 1'b0;
    logic              addr_b2 = 1'b0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic              fifo_full = 1'b0;
    logic              fifo_wr;
    logic [DATA_W-1:0] fifo_data;
    logic              last_n;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    // model state
    bit m_act = 0;
    int m_rem = 0;
    bit m_first = 0;
    bit m_drop = 0;
    int wr_seen = 0;

    always #(CLK_P/2) clk = ~clk;

    rd_align_feeder #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_count(xfer_count),
        .burst(burst), .agent64(agent64), .addr_b2(addr_b2), .rd_en(rd_en),
        .rd_data(rd_data), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .last_n(last_n)
    );

    function automatic int exp_total(int cnt, bit b, bit a, bit b2);
        int t;
        if (b || a) begin
            t = cnt + (b2 ? 1 : 0);
            if (t % 2 != 0) t = t + 1;
        end else begin
            t = cnt;
        end
        return t;
    endfunction

    function automatic int exp_writes(int cnt, bit b, bit a, bit b2);
        int t;
        t = exp_total(cnt, b, a, b2);
        if ((b || a) && b2 && t > 0) t = t - 1;
        return t;
    endfunction

    task automatic check(bit ok, string req, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // one clock cycle with inputs already driven after a falling edge
    task automatic cyc();
        bit acc, exp_wr, exp_last_n;
        logic [DATA_W-1:0] d;
        #1;
        exp_last_n = !(m_act && rd_en && m_rem == 1);
        check(last_n == exp_last_n, "R6", last_n, exp_last_n);
        acc = m_act && rd_en && !fifo_full;
        exp_wr = acc && !(m_first && m_drop);
        d = rd_data;
        @(posedge clk);
        #1;
        if (rd_en && fifo_full)
            check(fifo_wr == exp_wr, "R7", fifo_wr, exp_wr);
        else if (!m_act)
            check(fifo_wr == exp_wr, "R9", fifo_wr, exp_wr);
        else if (m_first && m_drop)
            check(fifo_wr == exp_wr, "R4", fifo_wr, exp_wr);
        else
            check(fifo_wr == exp_wr, "R8", fifo_wr, exp_wr);
        if (exp_wr && fifo_wr)
            check(fifo_data == d, "R8", fifo_data, d);
        if (fifo_wr) wr_seen++;
        if (acc) begin
            m_rem--;
            m_first = 0;
            if (m_rem == 0) m_act = 0;
        end
        @(negedge clk);
    endtask

    task automatic run_phase(int cnt, bit b, bit a, bit b2, int full_pct, bit poke);
        int tot;
        bit poked;
        string tag;
        poked = 0;
        tot = exp_total(cnt, b, a, b2);
        start = 1; xfer_count = CNT_W'(cnt); burst = b; agent64 = a; addr_b2 = b2;
        rd_en = 0;
        if (tot != 0) begin
            m_act = 1; m_rem = tot; m_first = 1; m_drop = (b || a) && b2;
        end
        wr_seen = 0;
        cyc();
        start = 0;
        while (m_act) begin
            rd_en = ($urandom % 100) < 70;
            fifo_full = ($urandom % 100) < full_pct;
            rd_data = $urandom;
            if (poke && ($urandom % 100) < 10) begin
                // R2: restart attempt while armed
                start = 1; xfer_count = CNT_W'($urandom % 9); burst = $urandom;
                addr_b2 = $urandom; poked = 1;
            end else begin
                start = 0;
            end
            cyc();
        end
        start = 0; rd_en = 0; fifo_full = 0;
        cyc();
        if (poked) tag = "R2";
        else if (!(b || a)) tag = "R5";
        else if (b2) tag = "R4";
        else tag = "R3";
        check(wr_seen == exp_writes(cnt, b, a, b2), tag, wr_seen, exp_writes(cnt, b, a, b2));
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'h5eed_1234));
        repeat (2) @(negedge clk);
        // R1
        check(fifo_wr == 0, "R1", fifo_wr, 0);
        check(last_n == 1, "R1", last_n, 1);
        rst_n = 1;
        @(negedge clk);
        // R9: offer words while idle
        rd_en = 1; rd_data = 32'hdead_beef;
        repeat (3) cyc();
        rd_en = 0;

        // directed corners
        run_phase(1, 0, 0, 0, 0, 0);   // R5 single word, last_n low whole phase
        run_phase(1, 0, 0, 1, 0, 0);   // R5 odd address, no drop
        run_phase(1, 1, 0, 1, 0, 0);   // R4 two words, first dropped
        run_phase(3, 1, 0, 0, 0, 0);   // R3 rounded to 4
        run_phase(4, 0, 1, 1, 20, 0);  // R4 agent64, 6 accepted
        run_phase(5, 1, 1, 1, 0, 0);   // R4 6 accepted, 5 written
        run_phase(6, 1, 0, 0, 40, 1);  // R2 restart ignored

        // R10: zero count non-aligned stays idle
        start = 1; xfer_count = 0; burst = 0; agent64 = 0; addr_b2 = 0;
        wr_seen = 0;
        cyc();
        start = 0; rd_en = 1;
        repeat (4) cyc();
        rd_en = 0;
        cyc();
        check(wr_seen == 0, "R10", wr_seen, 0);

        // R1: reset mid-phase returns to idle
        run_phase(2, 0, 0, 0, 0, 0);
        start = 1; xfer_count = 8; burst = 1; cyc(); start = 0;
        rst_n = 0; m_act = 0; #1;
        check(fifo_wr == 0, "R1", fifo_wr, 0);
        @(negedge clk); rst_n = 1;
        rd_en = 1; repeat (2) cyc(); rd_en = 0;

        // random phases
        for (int i = 0; i < 200; i++) begin
            run_phase($urandom % 12, $urandom, $urandom, $urandom, $urandom % 30, $urandom);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule